// File: doc/BRIEF.md
# Unaligned Word Read Splitter

This block serves full-word reads at any byte address. Behind it sits a memory that delivers only naturally aligned words. For an aligned address it makes one memory fetch and returns that word unchanged. For an address that is not a multiple of the word size, it fetches the aligned word that holds the first requested byte, then the word after it. It then picks the requested bytes out of the pair with a byte-granular funnel shift.

The result is little-endian. The byte at the requested address lands in bits [7:0], and each higher address takes the next byte lane up. A misaligned read costs roughly twice the memory time of an aligned one. The block accepts a new request only when idle. The memory port issues its fetches in increasing address order, with no more than one fetch in flight.

Top module: `unaligned_read_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: A request whose address has all low log2(W_BYTES) bits zero causes exactly one memory fetch, at word address `req_addr >> log2(W_BYTES)`.
- R3: A request whose low address bits are not all zero causes exactly two memory fetches. The first is at word address `req_addr >> log2(W_BYTES)`, the second at that word address plus one.
- R4: The second fetch address wraps modulo 2^(ADDR_W - log2(W_BYTES)), so a misaligned request in the last word continues at word 0.
- R5: Byte lane i of `rsp_data` (bits [8i+7:8i]) equals the memory byte at byte address (`req_addr` + i) modulo 2^ADDR_W.
- R6: `rsp_valid` rises only after the memory has answered every fetch of the request, stays low between the two fetches, and is high for exactly one cycle.
- R7: `mem_req_valid` is never high while an accepted fetch still awaits its `mem_rsp_valid`.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the response has been given.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high with an unchanged `mem_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the word to read |
| rsp_valid | output | 1 | One-cycle pulse marking `rsp_data` valid |
| rsp_data | output | 8*W_BYTES | Requested bytes, lowest address in the low byte |
| mem_req_valid | output | 1 | Aligned fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch this cycle |
| mem_req_addr | output | ADDR_W-log2(W_BYTES) | Word address of the fetch |
| mem_rsp_valid | input | 1 | Fetched word present |
| mem_rsp_data | input | 8*W_BYTES | Fetched aligned word |

## Verification
A small configuration of four-byte words and an 8-bit address is swept over every byte address. This covers every offset, every word, and the top-of-memory wrap. Each memory byte holds an arithmetic function of its address, so a lane that is shifted or swapped the wrong way, or taken from the wrong word, shows up as a mismatch. The bench memory varies its accept stalls and response latency from request to request. The fetch-count and fetch-address checks separate aligned requests from misaligned ones, and counting answered fetches at the moment of the response catches a result given early.

// File: rtl/unaligned_read_splitter.sv
module unaligned_read_splitter #(
  parameter int W_BYTES = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  output logic [8*W_BYTES-1:0]        rsp_data,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-$clog2(W_BYTES)-1:0] mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [8*W_BYTES-1:0]        mem_rsp_data
);
  localparam int OFF_W = $clog2(W_BYTES);
  localparam int WA_W  = ADDR_W - OFF_W;
  localparam int DW    = 8 * W_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic              second_q;
  logic [DW-1:0]     lo_q, hi_q;

  wire [OFF_W-1:0] off   = addr_q[OFF_W-1:0];
  wire             split = |off;
  wire [WA_W-1:0]  wa    = addr_q[ADDR_W-1:OFF_W];
  wire [2*DW-1:0]  pair  = {hi_q, lo_q};

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_DONE);
  assign mem_req_valid = (state == S_ISSUE);
  assign mem_req_addr  = wa + WA_W'(second_q);
  assign rsp_data      = DW'(pair >> {off, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      second_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            addr_q   <= req_addr;
            second_q <= 1'b0;
            state    <= S_ISSUE;
          end
        S_ISSUE:
          if (mem_req_ready) state <= S_WAIT;
        S_WAIT:
          if (mem_rsp_valid) begin
            if (second_q) begin
              hi_q  <= mem_rsp_data;
              state <= S_DONE;
            end else begin
              lo_q <= mem_rsp_data;
              if (split) begin
                second_q <= 1'b1;
                state    <= S_ISSUE;
              end else begin
                state <= S_DONE;
              end
            end
          end
        default:
          state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unaligned_read_splitter_chk.sv
module unaligned_read_splitter_chk #(
  parameter int WA_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [WA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid
);
  logic outst;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req_valid);

  // R9
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  rsp_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !outst && !mem_req_valid);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

bind unaligned_read_splitter unaligned_read_splitter_chk #(.WA_W(WA_W)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/unaligned_read_splitter_test.sv
module unaligned_read_splitter_test;
  localparam int WB    = 4;
  localparam int AW    = 8;
  localparam int OFF_W = $clog2(WB);
  localparam int WA_W  = AW - OFF_W;
  localparam int DW    = 8 * WB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [WA_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int nf = 0;
  int nr = 0;
  int cyc = 0;
  logic [WA_W-1:0] fa0, fa1;

  always #2 clk = ~clk;

  unaligned_read_splitter #(.W_BYTES(WB), .ADDR_W(AW)) uut (.*);

  function automatic logic [7:0] mbyte(int a);
    return 8'((((a % (1 << AW)) * 37) + 11) & 255);
  endfunction

  function automatic logic [DW-1:0] mword(int wa);
    logic [DW-1:0] w;
    for (int j = 0; j < WB; j++) w[8*j +: 8] = mbyte(wa * WB + j);
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: stalls and latency vary with the cycle count
  initial begin
    bit acc_prev = 0;
    bit pending = 0;
    int lat = 0;
    logic [WA_W-1:0] acc_addr = '0;
    logic [WA_W-1:0] paddr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (acc_prev) begin
        pending = 1;
        lat = cyc % 3;
        paddr = acc_addr;
        if (nf == 0) fa0 = acc_addr; else fa1 = acc_addr;
        nf++;
      end
      if (pending) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mword(int'(paddr));
          pending = 0;
          nr++;
        end else lat--;
      end
      mem_req_ready = !pending && (cyc % 5 != 2);
      acc_prev = rst_n && mem_req_valid && mem_req_ready;
      acc_addr = mem_req_addr;
    end
  end

  task automatic do_read(int a);
    bit done = 0;
    int expf;
    logic [DW-1:0] exp;
    @(negedge clk); #1;
    nf = 0; nr = 0;
    req_addr = AW'(a);
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    for (int t = 0; t < 60 && !done; t++) begin
      if (rsp_valid) done = 1;
      else begin
        chk(!req_ready, "R8", 64'(req_ready), 64'd0);
        @(negedge clk); #1;
      end
    end
    chk(done, "R6 timeout", 64'(done), 64'd1);
    expf = (a % WB == 0) ? 1 : 2;
    for (int i = 0; i < WB; i++) exp[8*i +: 8] = mbyte(a + i);
    chk(rsp_data == exp, "R5", 64'(rsp_data), 64'(exp));
    chk(nf == expf, (expf == 1) ? "R2 count" : "R3 count", 64'(nf), 64'(expf));
    chk(nr == expf, "R6 early", 64'(nr), 64'(expf));
    chk(fa0 == WA_W'(a / WB), "R2 first addr", 64'(fa0), 64'(a / WB));
    if (expf == 2)
      chk(fa1 == WA_W'(a / WB + 1), (a / WB == (1 << WA_W) - 1) ? "R4 wrap" : "R3 second addr",
          64'(fa1), 64'(WA_W'(a / WB + 1)));
    @(negedge clk); #1;
    chk(!rsp_valid, "R6 pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mem_req_valid == 1'b0, "R1 mem", 64'(mem_req_valid), 64'd0);
    for (int a = 0; a < (1 << AW); a++) do_read(a);
    do_read((1 << AW) - 1);
    do_read((1 << AW) - WB);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule